// File: doc/BRIEF.md
# Watermark Register Update Engine

This block keeps a shadow bank of arbitration watermarks for four clock-state sets. Every set carries five thresholds: data urgency, page-table urgency, self-refresh entry, self-refresh exit and memory clock change. A client hands over one request at a time through a valid/ready handshake. Each request names a set, a field, a duration in nanoseconds and a flag that permits lowering. The engine turns the duration into reference-clock cycles as floor(ns × MHz / 1000), saturates the count at 21 bits and stores it. It also stores the nanosecond value it accepted.

Unless the lowering flag is set, a field only moves upward. A request whose duration is not strictly larger than the last accepted one for that field is consumed and has no effect. After a batch of requests, a commit pulse loads a saturation level and a minimum outstanding-request count. A combinational read port returns both the cycle count and the accepted nanosecond value of any field.

Top module: `wm_update_engine`

## Requirements
- R1: A written field holds floor(ns × refclk_mhz / 1000), where refclk_mhz is the value on the reference-clock input when the request is accepted.
- R2: The stored cycle count saturates at 0x1FFFFF and never wraps, including for the largest ns and MHz inputs.
- R3: When the lowering flag is clear, a request writes only if its ns value is strictly greater than the field's last accepted ns. Equal or smaller requests leave both the cycle count and the ns value unchanged.
- R4: When the lowering flag is set, a request writes unconditionally, and this includes lowering the field.
- R5: An accepted write replaces the field's stored ns with the request's ns. A rejected request leaves it as it was.
- R6: With the self-refresh parameter off, field codes 2 (self-refresh entry) and 3 (self-refresh exit) read as zero and ignore every request. Field code 0 is data urgency, 1 is page-table urgency and 4 is memory clock change.
- R7: Field codes 5 to 7 are consumed in one cycle, change nothing and leave ready high.
- R8: After a handshake that writes, ready stays low for exactly 49 sampled cycles with the default widths (48-bit product plus one). A request that does not write leaves ready high in the next cycle.
- R9: A commit pulse loads the saturation level with 60 × refclk_mhz and the minimum outstanding count with 68. This holds even while a write is in progress.
- R10: Reset clears every stored ns value, every cycle count, the saturation level and the outstanding count, so the first nonzero request to any field is written.
- R11: A write touches only the addressed set and field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request will be taken |
| req_set_i | input | 2 | Clock-state set index 0..3 |
| req_field_i | input | 3 | Field code |
| req_ns_i | input | 32 | Requested watermark in ns |
| req_safe_lower_i | input | 1 | Permit lowering |
| refclk_mhz_i | input | 16 | Reference clock in MHz |
| commit_i | input | 1 | End-of-batch pulse |
| sat_level_o | output | 22 | Saturation level |
| min_outstanding_o | output | 8 | Minimum outstanding requests |
| rd_set_i | input | 2 | Read set index |
| rd_field_i | input | 3 | Read field code |
| rd_cycles_o | output | 21 | Stored cycle count |
| rd_ns_o | output | 32 | Last accepted ns |

## Verification
A commit pulse can land while the sequential divide of an earlier write is still running. In that case the two actions must stay independent. The bench fires a commit ten cycles after a write is accepted. It then checks that the saturation level settles on the next cycle, that the write still completes after exactly 49 low-ready cycles, and that the whole bank matches the behavioural model afterwards. A second instance with the self-refresh fields disabled checks that requests to those fields are consumed at once and read back as zero.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int WM_SETS   = 4;
  localparam int WM_FIELDS = 5;
  localparam int FIELD_W   = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_DATA    = 3'd0,
    FLD_PTE     = 3'd1,
    FLD_SR_IN   = 3'd2,
    FLD_SR_OUT  = 3'd3,
    FLD_MCLK    = 3'd4
  } wm_field_e;

  typedef enum logic {ST_IDLE, ST_BUSY} wm_state_e;
endpackage

// File: rtl/wm_div_const.sv
module wm_div_const #(
  parameter int DVD_W   = 48,
  parameter int DIVISOR = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dvd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int REM_W = $clog2(DIVISOR) + 1;
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [REM_W-1:0] rem_q, trial;
  logic [DVD_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, ge;

  // one restoring step per cycle; acc shifts dividend out, quotient in
  assign trial = {rem_q[REM_W-2:0], acc_q[DVD_W-1]};
  assign ge    = trial >= REM_W'(DIVISOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q  <= dvd_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? trial - REM_W'(DIVISOR) : trial;
        acc_q <= {acc_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = acc_q;

  a_r8_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r1_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < REM_W'(DIVISOR));
endmodule

// File: rtl/wm_shadow_bank.sv
module wm_shadow_bank #(
  parameter int NS_W    = 32,
  parameter int CYC_W   = 21,
  parameter int ENTRIES = 20,
  parameter int FIELDS  = 5,
  parameter int SR_EN   = 1,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [NS_W-1:0]  wns_i,
  input  logic [CYC_W-1:0] wcyc_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [NS_W-1:0]  rd_ns_o,
  output logic [CYC_W-1:0] rd_cyc_o,
  input  logic [IDX_W-1:0] pol_idx_i,
  output logic [NS_W-1:0]  pol_ns_o
);
  logic [NS_W-1:0]  ns_q  [ENTRIES];
  logic [CYC_W-1:0] cyc_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam int FLD = e % FIELDS;
    if (SR_EN == 0 && (FLD == 2 || FLD == 3)) begin : g_absent
      assign ns_q[e]  = '0;
      assign cyc_q[e] = '0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ns_q[e]  <= '0;
          cyc_q[e] <= '0;
        end else if (we_i && widx_i == IDX_W'(e)) begin
          ns_q[e]  <= wns_i;
          cyc_q[e] <= wcyc_i;
        end
      end
      a_r5_hold_unwritten: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && widx_i == IDX_W'(e)) |=> $stable(ns_q[e]) && $stable(cyc_q[e]));
    end
  end

  assign rd_ns_o  = (rd_idx_i  < IDX_W'(ENTRIES)) ? ns_q[rd_idx_i]   : '0;
  assign rd_cyc_o = (rd_idx_i  < IDX_W'(ENTRIES)) ? cyc_q[rd_idx_i]  : '0;
  assign pol_ns_o = (pol_idx_i < IDX_W'(ENTRIES)) ? ns_q[pol_idx_i]  : '0;
endmodule

// File: rtl/wm_update_engine.sv
module wm_update_engine
  import wm_pkg::*;
#(
  parameter int NS_W            = 32,
  parameter int MHZ_W           = 16,
  parameter int CYC_W           = 21,
  parameter int SETS            = WM_SETS,
  parameter int SR_EN           = 1,
  parameter int DIVISOR         = 1000,
  parameter int SAT_MULT        = 60,
  parameter int MIN_OUTSTANDING = 68,
  parameter int MINOUT_W        = 8,
  parameter int SET_W           = $clog2(SETS),
  parameter int SAT_W           = MHZ_W + $clog2(SAT_MULT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [SET_W-1:0]    req_set_i,
  input  logic [FIELD_W-1:0]  req_field_i,
  input  logic [NS_W-1:0]     req_ns_i,
  input  logic                req_safe_lower_i,
  input  logic [MHZ_W-1:0]    refclk_mhz_i,
  input  logic                commit_i,
  output logic [SAT_W-1:0]    sat_level_o,
  output logic [MINOUT_W-1:0] min_outstanding_o,
  input  logic [SET_W-1:0]    rd_set_i,
  input  logic [FIELD_W-1:0]  rd_field_i,
  output logic [CYC_W-1:0]    rd_cycles_o,
  output logic [NS_W-1:0]     rd_ns_o
);
  localparam int ENTRIES = SETS * WM_FIELDS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int PROD_W  = NS_W + MHZ_W;
  localparam int CHK_W   = PROD_W + $clog2(DIVISOR) + 1;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  function automatic logic field_ok(logic [FIELD_W-1:0] f);
    return (f < FIELD_W'(WM_FIELDS)) &&
           (SR_EN != 0 || (f != FLD_SR_IN && f != FLD_SR_OUT));
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(logic [SET_W-1:0] s, logic [FIELD_W-1:0] f);
    return IDX_W'(s) * IDX_W'(WM_FIELDS) + IDX_W'(f);
  endfunction

  wm_state_e         st_q;
  logic [IDX_W-1:0]  lat_idx_q, req_idx, rd_idx, pol_idx;
  logic [NS_W-1:0]   lat_ns_q, pol_ns;
  logic [PROD_W-1:0] lat_prod_q, prod_c, quot;
  logic              lat_safe_q, fire, allowed, start, div_busy, div_done, bank_we;
  logic [CYC_W-1:0]  wcyc;
  logic [SAT_W-1:0]  sat_q;
  logic [MINOUT_W-1:0] minout_q;

  assign req_ready_o = (st_q == ST_IDLE);
  assign req_idx     = field_ok(req_field_i) ? to_idx(req_set_i, req_field_i) : '0;
  assign rd_idx      = field_ok(rd_field_i)  ? to_idx(rd_set_i, rd_field_i)   : IDX_W'(ENTRIES);
  assign pol_idx     = (st_q == ST_BUSY) ? lat_idx_q : req_idx;
  assign fire        = req_valid_i && req_ready_o;
  assign allowed     = field_ok(req_field_i) && (req_safe_lower_i || req_ns_i > pol_ns);
  assign start       = fire && allowed;
  assign prod_c      = PROD_W'(req_ns_i) * PROD_W'(refclk_mhz_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      lat_idx_q  <= '0;
      lat_ns_q   <= '0;
      lat_prod_q <= '0;
      lat_safe_q <= 1'b0;
    end else if (start) begin
      st_q       <= ST_BUSY;
      lat_idx_q  <= req_idx;
      lat_ns_q   <= req_ns_i;
      lat_prod_q <= prod_c;
      lat_safe_q <= req_safe_lower_i;
    end else if (st_q == ST_BUSY && div_done) begin
      st_q <= ST_IDLE;
    end
  end

  wm_div_const #(.DVD_W(PROD_W), .DIVISOR(DIVISOR)) u_div (
    .clk_i, .rst_ni,
    .start_i (start),
    .dvd_i   (prod_c),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (quot)
  );

  assign bank_we = (st_q == ST_BUSY) && div_done;
  assign wcyc    = (quot > PROD_W'(CYC_MAX)) ? CYC_MAX : quot[CYC_W-1:0];

  wm_shadow_bank #(
    .NS_W(NS_W), .CYC_W(CYC_W), .ENTRIES(ENTRIES), .FIELDS(WM_FIELDS), .SR_EN(SR_EN)
  ) u_bank (
    .clk_i, .rst_ni,
    .we_i      (bank_we),
    .widx_i    (lat_idx_q),
    .wns_i     (lat_ns_q),
    .wcyc_i    (wcyc),
    .rd_idx_i  (rd_idx),
    .rd_ns_o   (rd_ns_o),
    .rd_cyc_o  (rd_cycles_o),
    .pol_idx_i (pol_idx),
    .pol_ns_o  (pol_ns)
  );

  // end-of-batch arbiter tuning, independent of the write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q    <= '0;
      minout_q <= '0;
    end else if (commit_i) begin
      sat_q    <= SAT_W'(SAT_MULT) * SAT_W'(refclk_mhz_i);
      minout_q <= MINOUT_W'(MIN_OUTSTANDING);
    end
  end

  assign sat_level_o       = sat_q;
  assign min_outstanding_o = minout_q;

  a_r1_quotient_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> (CHK_W'(quot) * CHK_W'(DIVISOR) <= CHK_W'(lat_prod_q)) &&
                 ((CHK_W'(quot) + 1'b1) * CHK_W'(DIVISOR) > CHK_W'(lat_prod_q)));
  a_r3_only_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we && !lat_safe_q) |-> lat_ns_q > pol_ns);
  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !req_ready_o);
  a_r9_commit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> sat_level_o == SAT_W'(SAT_MULT) * SAT_W'($past(refclk_mhz_i)) &&
                 min_outstanding_o == MINOUT_W'(MIN_OUTSTANDING));
endmodule

// File: tb/wm_update_engine_test.sv
module wm_update_engine_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, valid2 = 1'b0, safe = 1'b0, commit = 1'b0;
  logic [1:0]  set = '0, rset = '0;
  logic [2:0]  field = '0, rfield = '0;
  logic [31:0] ns = '0;
  logic [15:0] mhz = 16'd100;
  logic        ready, ready2;
  logic [21:0] sat, sat2;
  logic [7:0]  minout, minout2;
  logic [20:0] rcyc, rcyc2;
  logic [31:0] rns, rns2;

  int errors = 0, checks = 0;
  bit finished = 0;
  longint exp_ns [4][5];
  longint exp_cyc[4][5];

  always #5 clk = ~clk;

  wm_update_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_set_i(set), .req_field_i(field), .req_ns_i(ns), .req_safe_lower_i(safe),
    .refclk_mhz_i(mhz), .commit_i(commit), .sat_level_o(sat), .min_outstanding_o(minout),
    .rd_set_i(rset), .rd_field_i(rfield), .rd_cycles_o(rcyc), .rd_ns_o(rns));

  wm_update_engine #(.SR_EN(0)) uut_nosr (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid2), .req_ready_o(ready2),
    .req_set_i(set), .req_field_i(field), .req_ns_i(ns), .req_safe_lower_i(safe),
    .refclk_mhz_i(mhz), .commit_i(1'b0), .sat_level_o(sat2), .min_outstanding_o(minout2),
    .rd_set_i(rset), .rd_field_i(rfield), .rd_cycles_o(rcyc2), .rd_ns_o(rns2));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint conv(longint n, longint m);
    longint r = (n * m) / 1000;
    return (r > 64'h1FFFFF) ? 64'h1FFFFF : r;
  endfunction

  task automatic verify_all(input string tag);
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 5; f++) begin
        @(negedge clk);
        rset = 2'(s); rfield = 3'(f);
        #1;
        chk(rcyc == 21'(exp_cyc[s][f]), tag, rcyc, exp_cyc[s][f]);
        chk(rns == 32'(exp_ns[s][f]), tag, rns, exp_ns[s][f]);
      end
  endtask

  task automatic send(input int s, input int f, input longint n, input bit sl, input string tag);
    bit wr;
    int low;
    wr = (f < 5) && (sl || n > exp_ns[s][f]);
    @(negedge clk);
    set = 2'(s); field = 3'(f); ns = 32'(n); safe = sl; valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
    if (wr) begin
      exp_ns[s][f]  = n;
      exp_cyc[s][f] = conv(n, longint'(mhz));
      low = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (ready) break;
        low++;
      end
      chk(low == 49, "R8 ready low cycles", low, 49);
    end else begin
      @(negedge clk);
      chk(ready == 1'b1, (f >= 5) ? "R7 ready" : "R8 ready", ready, 1);
    end
    verify_all(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int low;
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 5; f++) begin exp_ns[s][f] = 0; exp_cyc[s][f] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sat == 0, "R10 sat reset", sat, 0);
    chk(minout == 0, "R10 minout reset", minout, 0);
    chk(ready == 1, "R10 ready reset", ready, 1);
    verify_all("R10 reset bank");

    send(0, 0, 1500, 0, "R10 first write");
    send(0, 0, 1500, 0, "R3 equal rejected");
    send(0, 0, 1000, 0, "R3 lower rejected");
    send(0, 0, 2000, 0, "R3 higher accepted");
    send(0, 0, 500, 1, "R4 safe lower");
    mhz = 16'd400;
    send(3, 4, 12345, 0, "R1 convert");
    send(1, 2, 7, 0, "R1 floor");
    send(2, 6, 9999, 1, "R7 bad field");
    mhz = 16'hFFFF;
    send(2, 3, 64'hFFFFFFFF, 0, "R2 clamp max inputs");
    mhz = 16'd1000;
    send(1, 1, 2097151, 0, "R2 exact max");
    send(1, 1, 2097152, 0, "R2 one over");
    send(1, 4, 10, 0, "R11 neighbour");

    // commit lands while a write is dividing
    mhz = 16'd100;
    fork
      send(2, 0, 3000, 0, "R5/R11 write with commit");
      begin
        repeat (10) @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk(sat == 22'd6000, "R9 sat level", sat, 6000);
        chk(minout == 8'd68, "R9 minout", minout, 68);
        chk(ready == 0, "R9 write still busy", ready, 0);
      end
    join

    // instance without self-refresh fields
    @(negedge clk);
    set = 2'd1; field = 3'd2; ns = 32'd5000; safe = 1'b1; valid2 = 1'b1;
    @(posedge clk);
    #1 valid2 = 1'b0;
    @(negedge clk);
    chk(ready2 == 1, "R6 ready stays high", ready2, 1);
    rset = 2'd1; rfield = 3'd2;
    #1;
    chk(rcyc2 == 0, "R6 sr enter cycles", rcyc2, 0);
    chk(rns2 == 0, "R6 sr enter ns", rns2, 0);
    @(negedge clk);
    field = 3'd4; valid2 = 1'b1;
    @(posedge clk);
    #1 valid2 = 1'b0;
    low = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (ready2) break;
      low++;
    end
    chk(low == 49, "R6 present field writes", low, 49);
    rfield = 3'd4;
    #1;
    chk(rcyc2 == 21'd500, "R6 present field value", rcyc2, 500);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule